// File: doc/BRIEF.md
# Low-Power Mode Sequencer

This block is a per-core power controller built around a small byte-code engine. Software fills a 64-byte sequence memory through a simple register port, then picks an entry index and sets an enable bit in a control register. When the core raises its wait-for-interrupt indication while the engine is enabled, the engine begins stepping through commands from that index. Each command drives a control-line bus, inserts a programmable delay, parks until a wake interrupt, or ends the sequence.

Several low-power modes can live in the same memory and differ only in their entry index. For example, a light standby sequence can start at index 0 and a deeper power-collapse sequence at index 3. The `core_sleep` output stays high for the whole run. It drops when the end command is executed, which releases the core.

Top module: `lpm_sequencer`

## Requirements
- R1: After reset, `core_sleep` is 0, `ctl_out` is 0, and the config, control, delay and status registers all read 0.
- R2: Register map (byte addresses): config 0x08 and delay 0x34 are plain 32-bit read/write storage. Control 0x30 keeps all 32 written bits; bit 0 is enable and bits 10:4 are the entry index. Status 0x38 reads the program counter in bits 6:0 and the busy flag in bit 8. Sequence word k is at 0x80+4k for k in 0..15 and reads back what was written.
- R3: Sequence bytes are little-endian within each word: byte index n is bits 8*(n%4)+7 : 8*(n%4) of word n/4.
- R4: With enable set, a `core_wfi` sampled high on an edge while idle raises `core_sleep` at that edge and loads the entry index into the program counter. The command at that index executes on the following edge.
- R5: With enable clear, `core_wfi` has no effect: `core_sleep` stays 0.
- R6: Any byte that is not one of the special commands executes in one cycle and drives its low 7 bits onto `ctl_out`. The special commands are 0x80 (end), 0x40 (wait) and 0x20 to 0x2F (delay).
- R7: Byte 0x40 (wait) stalls the program counter and `ctl_out` until `wake_irq` is sampled high. The next command then executes on the following edge.
- R8: A `wake_irq` sampled high during a run before a wait command is reached is remembered, so that wait completes in one cycle.
- R9: A delay byte 0x2x takes its count N from byte lane x[1:0] of the delay register and occupies N+1 cycles in total.
- R10: Byte 0x80 ends the run: `core_sleep` falls at the edge that executes it and the program counter stays on it. A program counter of 64 or more reads as an end command.
- R11: Writes to the control register or the sequence memory while busy are ignored.
- R12: Different entry indexes run different sequences from the same memory.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 8 | Register byte address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr` (combinational) |
| core_wfi | input | 1 | Core wait-for-interrupt indication |
| wake_irq | input | 1 | Wake interrupt |
| core_sleep | output | 1 | High while a sequence is running |
| ctl_out | output | 7 | Registered control-line bus |

## Verification
A corrupted program counter or a wrong byte-lane select shows up within one cycle as a wrong `ctl_out` value or a misplaced fall of `core_sleep`. The bench predicts both to the exact edge from its own copy of the program. A lost wake latch or a wait that ignores the wake shows as `core_sleep` staying high past its predicted edge. A delay miscount shifts the next `ctl_out` change by the error. Writes that leak through while busy become visible on the next read of the control register or the sequence word.

// File: rtl/lpm_sequencer.sv
module lpm_sequencer #(
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 32,
  parameter int SEQ_WORDS = 16,
  parameter int CTL_W     = 7,
  parameter int IDX_W     = 7,
  parameter int CNT_W     = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  input  logic              core_wfi,
  input  logic              wake_irq,
  output logic              core_sleep,
  output logic [CTL_W-1:0]  ctl_out
);
  localparam int SEQ_BYTES = SEQ_WORDS * 4;
  localparam int WAW       = $clog2(SEQ_WORDS);
  localparam logic [ADDR_W-1:0] A_CFG  = ADDR_W'(8'h08);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(8'h30);
  localparam logic [ADDR_W-1:0] A_DLY  = ADDR_W'(8'h34);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(8'h38);
  localparam logic [ADDR_W-1:0] A_SEQ  = ADDR_W'(8'h80);
  localparam logic [7:0] OP_END  = 8'h80;
  localparam logic [7:0] OP_WAIT = 8'h40;

  typedef enum logic [1:0] {S_IDLE, S_RUN, S_DELAY, S_WAIT} st_t;

  st_t                st;
  logic [DATA_W-1:0]  cfg_q, ctrl_q, dly_q;
  logic [DATA_W-1:0]  mem [SEQ_WORDS];
  logic [IDX_W-1:0]   pc;
  logic [CNT_W-1:0]   cnt;
  logic               wake_pend;
  logic [7:0]         cur;
  logic [CNT_W-1:0]   dfield;
  logic [ADDR_W-1:0]  woff;
  logic               seq_hit;
  logic [WAW-1:0]     wsel;
  logic               busy;

  assign busy       = (st != S_IDLE);
  assign core_sleep = busy;
  assign woff       = addr - A_SEQ;
  assign seq_hit    = (addr >= A_SEQ) && (woff < ADDR_W'(SEQ_BYTES));
  assign wsel       = woff[WAW+1:2];
  assign cur        = (pc < IDX_W'(SEQ_BYTES)) ? mem[pc[WAW+1:2]][{pc[1:0], 3'b000} +: 8] : OP_END;
  assign dfield     = dly_q[{cur[1:0], 3'b000} +: CNT_W];

  always_comb begin
    rdata = '0;
    if (seq_hit) rdata = mem[wsel];
    else begin
      case (addr)
        A_CFG:  rdata = cfg_q;
        A_CTRL: rdata = ctrl_q;
        A_DLY:  rdata = dly_q;
        A_STAT: rdata = DATA_W'({busy, 1'b0, pc});
        default: rdata = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE;
      cfg_q <= '0; ctrl_q <= '0; dly_q <= '0;
      for (int i = 0; i < SEQ_WORDS; i++) mem[i] <= '0;
      pc <= '0; cnt <= '0; wake_pend <= 1'b0; ctl_out <= '0;
    end else begin
      if (wr_en) begin
        if (seq_hit) begin
          if (!busy) mem[wsel] <= wdata;
        end else begin
          case (addr)
            A_CFG:  cfg_q <= wdata;
            A_DLY:  dly_q <= wdata;
            A_CTRL: if (!busy) ctrl_q <= wdata;
            default: ;
          endcase
        end
      end

      if (!busy) wake_pend <= 1'b0;
      else if (wake_irq) wake_pend <= 1'b1;

      case (st)
        S_IDLE: if (ctrl_q[0] && core_wfi) begin
          pc <= ctrl_q[4 +: IDX_W];
          st <= S_RUN;
        end
        S_RUN: begin
          if (cur == OP_END) st <= S_IDLE;
          else if (cur == OP_WAIT) begin
            if (wake_pend || wake_irq) begin
              pc <= pc + 1'b1;
              wake_pend <= 1'b0;
            end else st <= S_WAIT;
          end else if (cur[7:4] == 4'h2) begin
            cnt <= dfield;
            if (dfield == '0) pc <= pc + 1'b1;
            else st <= S_DELAY;
          end else begin
            ctl_out <= cur[CTL_W-1:0];
            pc <= pc + 1'b1;
          end
        end
        S_DELAY: begin
          cnt <= cnt - 1'b1;
          if (cnt == CNT_W'(1)) begin
            pc <= pc + 1'b1;
            st <= S_RUN;
          end
        end
        S_WAIT: if (wake_irq) begin
          pc <= pc + 1'b1;
          wake_pend <= 1'b0;
          st <= S_RUN;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  a_r5_disabled_stays_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !ctrl_q[0]) |=> !core_sleep);
  a_r11_ctrl_locked_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && wr_en && addr == A_CTRL) |=> $stable(ctrl_q));
  a_r7_wait_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_WAIT && !wake_irq) |=> (st == S_WAIT && $stable(pc) && $stable(ctl_out)));
  a_r10_end_releases: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_RUN && cur == OP_END) |=> !core_sleep);
  a_r6_ctl_quiet_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |=> $stable(ctl_out));
endmodule

// File: tb/lpm_sequencer_tb.sv
module lpm_sequencer_tb_top;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        wr_en = 0;
  logic [7:0]  addr = 0;
  logic [31:0] wdata = 0;
  logic [31:0] rdata;
  logic        core_wfi = 0;
  logic        wake_irq = 0;
  logic        core_sleep;
  logic [6:0]  ctl_out;

  int n_run = 0, n_fail = 0;
  bit done = 0;
  logic [7:0] prog [64];

  always #5 clk = ~clk;

  lpm_sequencer dut_i (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .core_wfi(core_wfi), .wake_irq(wake_irq), .core_sleep(core_sleep),
    .ctl_out(ctl_out));

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    addr = a; wdata = d; wr_en = 1;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    addr = a; #1; d = rdata;
  endtask

  function automatic logic [31:0] pack(int w);
    return {prog[4*w+3], prog[4*w+2], prog[4*w+1], prog[4*w]};
  endfunction

  function automatic bit plain(logic [7:0] b);
    return !(b == 8'h80 || b == 8'h40 || b[7:4] == 4'h2);
  endfunction

  task automatic load_all();
    for (int w = 0; w < 16; w++) wr(8'h80 + 8'(4*w), pack(w));
  endtask

  task automatic pulse_wfi();
    core_wfi = 1; @(negedge clk); core_wfi = 0;
  endtask

  task automatic pulse_wake();
    wake_irq = 1; @(negedge clk); wake_irq = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog actual=%h expected=%h", 0, 1);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    void'($urandom(32'h5eed_1234));
    step(3);
    rst_n = 1;
    step(1);
    chk("R1 sleep", core_sleep, 0);
    chk("R1 ctl", ctl_out, 0);
    rd(8'h08, d); chk("R1 cfg", d, 0);
    rd(8'h30, d); chk("R1 ctrl", d, 0);
    rd(8'h34, d); chk("R1 dly", d, 0);
    rd(8'h38, d); chk("R1 status", d, 0);

    wr(8'h08, 32'h1234_5678);
    rd(8'h08, d); chk("R2 cfg rw", d, 32'h1234_5678);
    wr(8'h30, 32'hA5A5_F7F0);
    rd(8'h30, d); chk("R2 ctrl keeps all bits", d, 32'hA5A5_F7F0);
    pulse_wfi(); step(2);
    chk("R5 disabled ignores wfi", core_sleep, 0);

    for (int i = 0; i < 64; i++) prog[i] = 8'h80;
    prog[0] = 8'h05; prog[1] = 8'h40; prog[2] = 8'h80;
    prog[3] = 8'h0B; prog[4] = 8'h21; prog[5] = 8'h16; prog[6] = 8'h80;
    load_all();
    rd(8'h80, d); chk("R2 R3 seq word0", d, 32'h0B80_4005);
    rd(8'h84, d); chk("R2 seq word1", d, 32'h8080_1621);
    wr(8'h34, 32'h3C10_0500);

    // standby from index 0
    wr(8'h30, 32'h0000_0001);
    pulse_wfi();
    chk("R4 sleep at start edge", core_sleep, 1);
    step(1); chk("R3 R6 first byte lane0", ctl_out, 7'h05);
    step(10);
    chk("R7 still asleep in wait", core_sleep, 1);
    chk("R7 ctl held", ctl_out, 7'h05);
    rd(8'h38, d); chk("R7 R2 status pc and busy", d, 32'h0000_0101);
    wr(8'h30, 32'h0000_0031);
    rd(8'h30, d); chk("R11 ctrl write while busy", d, 32'h0000_0001);
    wr(8'h80, 32'hFFFF_FFFF);
    rd(8'h80, d); chk("R11 seq write while busy", d, 32'h0B80_4005);
    pulse_wake();
    chk("R7 resumes, not ended yet", core_sleep, 1);
    step(1); chk("R10 end releases", core_sleep, 0);
    rd(8'h38, d); chk("R10 pc stays on end", d, 32'h0000_0002);

    // power collapse from index 3 with delay lane1=5
    wr(8'h30, 32'h0000_0031);
    pulse_wfi();
    step(1); chk("R12 entry index 3", ctl_out, 7'h0B);
    step(5); chk("R9 delay not over", ctl_out, 7'h0B);
    step(1); chk("R9 delay last cycle", ctl_out, 7'h0B);
    step(1); chk("R9 after delay", ctl_out, 7'h16);
    chk("R9 still asleep", core_sleep, 1);
    step(1); chk("R10 collapse ends", core_sleep, 0);

    // early wake latched
    wr(8'h30, 32'h0000_0001);
    pulse_wfi();
    wake_irq = 1; step(1); wake_irq = 0;
    chk("R8 ctl", ctl_out, 7'h05);
    step(1); chk("R8 wait passed", core_sleep, 1);
    step(1); chk("R8 early wake completes", core_sleep, 0);

    // index out of memory range
    wr(8'h30, 32'h0000_0641);
    pulse_wfi();
    chk("R10 oor start", core_sleep, 1);
    step(1); chk("R10 oor ends", core_sleep, 0);
    chk("R10 oor ctl unchanged", ctl_out, 7'h05);
    rd(8'h38, d); chk("R10 oor pc", d, 32'h0000_0064);

    // random plain programs
    for (int t = 0; t < 25; t++) begin
      int len, st;
      logic [7:0] b;
      len = 1 + int'($urandom_range(0, 7));
      st = int'($urandom_range(0, 63 - len - 1));
      for (int i = 0; i < 64; i++) prog[i] = 8'h80;
      for (int i = 0; i < len; i++) begin
        do b = 8'($urandom); while (!plain(b));
        prog[st + i] = b;
      end
      load_all();
      wr(8'h30, {20'($urandom), 1'b0, 7'(st), 4'($urandom) | 4'h1});
      pulse_wfi();
      step(len);
      chk("R6 random last ctl", ctl_out, prog[st + len - 1][6:0]);
      chk("R4 random asleep", core_sleep, 1);
      step(1);
      chk("R10 random released", core_sleep, 0);
      rd(8'h38, d); chk("R2 random pc", d, 32'(st + len));
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule